// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the off-chip side of an 8051-class core. It takes instruction fetch requests and data-move read and write requests from the core and turns each accepted one into a fixed four-clock bus cycle. The low address byte and the data share one 8-bit port. The high address byte goes out on a second port. An address latch strobe marks the low address. One active-low enable serves as the output enable for program memory. Two active-low strobes control data memory reads and writes.

The core is stalled while the cycle runs and gets a one-cycle done pulse together with the read byte. The block also holds a small bank of 16-bit data pointers and the select register that picks the active one. Data accesses take their address either from the selected pointer or from an 8-bit working register combined with the port-2 latch. A fetch goes off-chip when the external-only input is low, or when its address lies at or above the on-chip program size.

Top module: `ext_bus_ctrl`

## Requirements
- R1: During and right after reset, ready_o=1, stall_o=0, done_o=0, ale_o=0, psen_no=rd_no=wr_no=1 and p0_oe_o=0. Both data pointers are 0 and the select value is 0.
- R2: A fetch request goes to the bus when ext_only_ni=0, whatever its address. When ext_only_ni=1, only addresses >= ONCHIP_BYTES (default 16'h4000) go to the bus. Lower addresses start no bus cycle and give no done pulse.
- R3: An accepted request starts T1 on the next clock, followed by T2, T3 and T4, and then the block is idle again. In T1, ale_o=1, p0_oe_o=1, p0_o is the low address byte and p2_o is the high address byte. In T2 to T4, ale_o=0 and p2_o still holds the high address byte.
- R4: psen_no is low only in T2 to T4 of a fetch. The strobe vector {psen_no,rd_no,wr_no} is 3'b011 for a fetch, 3'b101 for a read and 3'b110 for a write, and it is 3'b111 at all other times.
- R5: On a read or a fetch, p0_oe_o=0 in T2 to T4. The block samples p0_i at the clock that ends T4. The byte appears on rdata_o in the cycle after T4, while done_o=1.
- R6: On a write, p0_oe_o=1 and p0_o equals the write byte in T2 to T4. done_o pulses in the cycle after T4.
- R7: With data_ptr_i=0, the access address is {p2_latch_i, ri_val_i}.
- R8: With data_ptr_i=1, the address is the pointer chosen by the select value. dps_wr_i loads bit 0 of dps_wdata_i as the select value. dptr_wr_i writes dptr_wdata_i into the currently selected pointer only. dps_o and dptr_o show the select value and the selected pointer.
- R9: stall_o is 1 in T1 to T3 and 0 in T4. ready_o is 0 from T1 to T4.
- R10: A request that arrives while a cycle is running is ignored. When an off-chip fetch and a data request arrive in the same idle cycle, the fetch is taken.
- R11: While idle, p0_oe_o=0 and p2_o follows p2_latch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_only_ni | input | 1 | Low forces every fetch off-chip |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 16 | Fetch address |
| data_req_i | input | 1 | Data-move request |
| data_we_i | input | 1 | 1 = write, 0 = read |
| data_ptr_i | input | 1 | 1 = pointer address, 0 = register-indirect |
| ri_val_i | input | 8 | Working register value (low address byte) |
| wdata_i | input | 8 | Write byte |
| p2_latch_i | input | 8 | Port-2 output latch value |
| dps_wr_i | input | 1 | Write strobe for the pointer select register |
| dps_wdata_i | input | 8 | Select register write value |
| dptr_wr_i | input | 1 | Write strobe for the selected pointer |
| dptr_wdata_i | input | 16 | Pointer write value |
| dps_o | output | 1 | Current select value |
| dptr_o | output | 16 | Selected pointer |
| ready_o | output | 1 | Idle, can accept a request |
| stall_o | output | 1 | Core hold |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte read from the bus |
| p0_o | output | 8 | Shared address/data port output |
| p0_oe_o | output | 1 | Shared port output enable |
| p0_i | input | 8 | Shared port input |
| p2_o | output | 8 | High address / port-2 output |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program memory enable, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |

## Verification
A request driven on a falling edge is taken at the next rising edge. T1 can therefore be seen at the following falling edge, and T2, T3 and T4 at the three falling edges after it. done_o and rdata_o are due at the fifth falling edge. The bench samples every pin at each of these falling edges and compares it with values worked out from the address source, the access kind and the phase number. Fetches that stay on-chip, requests ignored while busy, and pointer and select writes are checked one falling edge after the clock that would have acted on them.

// File: rtl/ext_bus_pkg.sv
`timescale 1ns/1ps
package ext_bus_pkg;
  localparam int EB_DATA_W = 8;
  localparam int EB_ADDR_W = 16;

  typedef enum logic [2:0] {PH_IDLE, PH_T1, PH_T2, PH_T3, PH_T4} phase_e;
  typedef enum logic [1:0] {K_FETCH, K_READ, K_WRITE} kind_e;

  typedef struct packed {
    kind_e                 kind;
    logic [EB_ADDR_W-1:0]  addr;
    logic [EB_DATA_W-1:0]  wdata;
  } bus_req_t;
endpackage

// File: rtl/ebc_dptr_bank.sv
`timescale 1ns/1ps
module ebc_dptr_bank #(
  parameter int NUM_DPTR = 2,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  localparam int SEL_W   = (NUM_DPTR > 1) ? $clog2(NUM_DPTR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_wr_i,
  input  logic [DATA_W-1:0] sel_wdata_i,
  input  logic              ptr_wr_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] ptr_q [NUM_DPTR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_wr_i) sel_q <= sel_wdata_i[SEL_W-1:0];
  end

  for (genvar g = 0; g < NUM_DPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ptr_q[g] <= '0;
      else if (ptr_wr_i && sel_q == SEL_W'(g))    ptr_q[g] <= ptr_wdata_i;
    end
  end

  assign sel_o = sel_q;
  assign ptr_o = ptr_q[sel_q];
endmodule

// File: rtl/ebc_req_arb.sv
`timescale 1ns/1ps
module ebc_req_arb
  import ext_bus_pkg::*;
#(
  parameter int ONCHIP_BYTES = 16384
) (
  input  logic                 idle_i,
  input  logic                 ext_only_ni,
  input  logic                 fetch_req_i,
  input  logic [EB_ADDR_W-1:0] fetch_addr_i,
  input  logic                 data_req_i,
  input  logic                 data_we_i,
  input  logic                 data_ptr_i,
  input  logic [EB_DATA_W-1:0] ri_val_i,
  input  logic [EB_DATA_W-1:0] wdata_i,
  input  logic [EB_DATA_W-1:0] p2_latch_i,
  input  logic [EB_ADDR_W-1:0] dptr_i,
  output logic                 start_o,
  output bus_req_t             req_o
);
  logic fetch_ext;

  // external-only pin overrides the address split
  assign fetch_ext = fetch_req_i &&
                     (!ext_only_ni || (32'(fetch_addr_i) >= ONCHIP_BYTES));
  assign start_o   = idle_i && (fetch_ext || data_req_i);

  always_comb begin
    if (fetch_ext) begin
      req_o.kind  = K_FETCH;
      req_o.addr  = fetch_addr_i;
      req_o.wdata = '0;
    end else begin
      req_o.kind  = data_we_i ? K_WRITE : K_READ;
      req_o.addr  = data_ptr_i ? dptr_i : {p2_latch_i, ri_val_i};
      req_o.wdata = wdata_i;
    end
  end
endmodule

// File: rtl/ebc_bus_seq.sv
`timescale 1ns/1ps
module ebc_bus_seq
  import ext_bus_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  bus_req_t             req_i,
  input  logic [EB_DATA_W-1:0] p0_i,
  input  logic [EB_DATA_W-1:0] p2_latch_i,
  output logic                 idle_o,
  output logic                 stall_o,
  output logic                 done_o,
  output logic [EB_DATA_W-1:0] rdata_o,
  output logic [EB_DATA_W-1:0] p0_o,
  output logic                 p0_oe_o,
  output logic [EB_DATA_W-1:0] p2_o,
  output logic                 ale_o,
  output logic                 psen_no,
  output logic                 rd_no,
  output logic                 wr_no
);
  localparam int HI_W = EB_ADDR_W - EB_DATA_W;

  phase_e               phase_q;
  bus_req_t             req_q;
  logic [EB_DATA_W-1:0] rdata_q;
  logic                 done_q;
  logic                 strobe_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_T4);
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_T1;
          req_q   <= req_i;
        end
        PH_T1: phase_q <= PH_T2;
        PH_T2: phase_q <= PH_T3;
        PH_T3: phase_q <= PH_T4;
        PH_T4: begin
          phase_q <= PH_IDLE;
          if (req_q.kind != K_WRITE) rdata_q <= p0_i; // sample before strobe rises
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign strobe_ph = (phase_q == PH_T2) || (phase_q == PH_T3) || (phase_q == PH_T4);
  assign idle_o    = (phase_q == PH_IDLE);
  assign stall_o   = (phase_q == PH_T1) || (phase_q == PH_T2) || (phase_q == PH_T3);
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign ale_o     = (phase_q == PH_T1);
  assign psen_no   = !(strobe_ph && req_q.kind == K_FETCH);
  assign rd_no     = !(strobe_ph && req_q.kind == K_READ);
  assign wr_no     = !(strobe_ph && req_q.kind == K_WRITE);
  assign p0_oe_o   = (phase_q == PH_T1) || (strobe_ph && req_q.kind == K_WRITE);
  assign p0_o      = (phase_q == PH_T1) ? req_q.addr[EB_DATA_W-1:0] : req_q.wdata;
  assign p2_o      = idle_o ? p2_latch_i : EB_DATA_W'(req_q.addr[EB_ADDR_W-1 -: HI_W]);
endmodule

// File: rtl/ext_bus_ctrl.sv
`timescale 1ns/1ps
module ext_bus_ctrl
  import ext_bus_pkg::*;
#(
  parameter int ONCHIP_BYTES = 16384,
  parameter int NUM_DPTR     = 2,
  localparam int SEL_W       = (NUM_DPTR > 1) ? $clog2(NUM_DPTR) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ext_only_ni,
  input  logic                 fetch_req_i,
  input  logic [EB_ADDR_W-1:0] fetch_addr_i,
  input  logic                 data_req_i,
  input  logic                 data_we_i,
  input  logic                 data_ptr_i,
  input  logic [EB_DATA_W-1:0] ri_val_i,
  input  logic [EB_DATA_W-1:0] wdata_i,
  input  logic [EB_DATA_W-1:0] p2_latch_i,
  input  logic                 dps_wr_i,
  input  logic [EB_DATA_W-1:0] dps_wdata_i,
  input  logic                 dptr_wr_i,
  input  logic [EB_ADDR_W-1:0] dptr_wdata_i,
  output logic [SEL_W-1:0]     dps_o,
  output logic [EB_ADDR_W-1:0] dptr_o,
  output logic                 ready_o,
  output logic                 stall_o,
  output logic                 done_o,
  output logic [EB_DATA_W-1:0] rdata_o,
  output logic [EB_DATA_W-1:0] p0_o,
  output logic                 p0_oe_o,
  input  logic [EB_DATA_W-1:0] p0_i,
  output logic [EB_DATA_W-1:0] p2_o,
  output logic                 ale_o,
  output logic                 psen_no,
  output logic                 rd_no,
  output logic                 wr_no
);
  logic     idle, start;
  bus_req_t req;

  ebc_dptr_bank #(
    .NUM_DPTR (NUM_DPTR),
    .ADDR_W   (EB_ADDR_W),
    .DATA_W   (EB_DATA_W)
  ) u_dptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_wr_i    (dps_wr_i),
    .sel_wdata_i (dps_wdata_i),
    .ptr_wr_i    (dptr_wr_i),
    .ptr_wdata_i (dptr_wdata_i),
    .sel_o       (dps_o),
    .ptr_o       (dptr_o)
  );

  ebc_req_arb #(.ONCHIP_BYTES(ONCHIP_BYTES)) u_arb (
    .idle_i       (idle),
    .ext_only_ni  (ext_only_ni),
    .fetch_req_i  (fetch_req_i),
    .fetch_addr_i (fetch_addr_i),
    .data_req_i   (data_req_i),
    .data_we_i    (data_we_i),
    .data_ptr_i   (data_ptr_i),
    .ri_val_i     (ri_val_i),
    .wdata_i      (wdata_i),
    .p2_latch_i   (p2_latch_i),
    .dptr_i       (dptr_o),
    .start_o      (start),
    .req_o        (req)
  );

  ebc_bus_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .req_i      (req),
    .p0_i       (p0_i),
    .p2_latch_i (p2_latch_i),
    .idle_o     (idle),
    .stall_o    (stall_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .p0_o       (p0_o),
    .p0_oe_o    (p0_oe_o),
    .p2_o       (p2_o),
    .ale_o      (ale_o),
    .psen_no    (psen_no),
    .rd_no      (rd_no),
    .wr_no      (wr_no)
  );

  assign ready_o = idle;
endmodule

// File: rtl/ext_bus_ctrl_chk.sv
`timescale 1ns/1ps
module ext_bus_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       stall_o,
  input logic       done_o,
  input logic       ale_o,
  input logic       psen_no,
  input logic       rd_no,
  input logic       wr_no,
  input logic       p0_oe_o,
  input logic [7:0] p2_o,
  input logic [7:0] p2_latch_i
);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~psen_no, ~rd_no, ~wr_no}) <= 1);

  a_r3_ale_then_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && (!psen_no || !rd_no || !wr_no)));

  a_r9_stall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !ready_o);

  a_r9_last_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !ready_o) |=> (ready_o && done_o));

  a_r6_write_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> p0_oe_o);

  a_r5_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !psen_no) |-> !p0_oe_o);

  a_r11_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!p0_oe_o && !ale_o && psen_no && rd_no && wr_no && p2_o == p2_latch_i));
endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk u_chk (.*);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_only_ni = 1'b1;
  logic        fetch_req_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic        data_req_i = 1'b0, data_we_i = 1'b0, data_ptr_i = 1'b0;
  logic [7:0]  ri_val_i = '0, wdata_i = '0, p2_latch_i = 8'h5A;
  logic        dps_wr_i = 1'b0;
  logic [7:0]  dps_wdata_i = '0;
  logic        dptr_wr_i = 1'b0;
  logic [15:0] dptr_wdata_i = '0;
  logic        dps_o;
  logic [15:0] dptr_o;
  logic        ready_o, stall_o, done_o, p0_oe_o, ale_o, psen_no, rd_no, wr_no;
  logic [7:0]  rdata_o, p0_o, p2_o;
  logic [7:0]  p0_i = '0;

  int checks = 0;
  int failures = 0;
  bit inject_busy = 1'b0;

  always #4 clk_i = ~clk_i;

  ext_bus_ctrl uut (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // kind: 0 fetch, 1 read, 2 write; called just after a negedge with the request driven
  task automatic bus_cycle(input int kind, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rv, input string tag);
    logic [2:0] exp_str;
    exp_str = (kind == 0) ? 3'b011 : (kind == 1) ? 3'b101 : 3'b110;
    p0_i = rv;
    @(posedge clk_i); @(negedge clk_i);
    fetch_req_i = 1'b0; data_req_i = 1'b0;
    check({tag, " R3"}, "T1 ale", ale_o, 1);
    check({tag, " R3"}, "T1 p0_oe", p0_oe_o, 1);
    check({tag, " R3"}, "T1 addr lo", p0_o, a[7:0]);
    check({tag, " R3"}, "T1 addr hi", p2_o, a[15:8]);
    check({tag, " R4"}, "T1 strobes", {psen_no, rd_no, wr_no}, 3'b111);
    check({tag, " R9"}, "T1 stall", stall_o, 1);
    for (int t = 2; t <= 4; t++) begin
      @(negedge clk_i);
      if (t == 3) data_req_i = 1'b0;
      check({tag, " R3"}, "Tn ale", ale_o, 0);
      check({tag, " R3"}, "Tn addr hi", p2_o, a[15:8]);
      check({tag, " R4"}, "Tn strobes", {psen_no, rd_no, wr_no}, exp_str);
      check({tag, " R5 R6"}, "Tn p0_oe", p0_oe_o, kind == 2);
      if (kind == 2) check({tag, " R6"}, "Tn wdata", p0_o, wd);
      check({tag, " R9"}, "Tn stall", stall_o, t < 4);
      check({tag, " R9"}, "Tn ready", ready_o, 0);
      if (t == 2 && inject_busy) begin
        data_req_i = 1'b1; data_we_i = 1'b1; data_ptr_i = 1'b0;
      end
    end
    @(negedge clk_i);
    check({tag, " R5"}, "done", done_o, 1);
    check({tag, " R9"}, "ready after", ready_o, 1);
    if (kind != 2) check({tag, " R5"}, "rdata", rdata_o, rv);
  endtask

  task automatic no_cycle(input string tag);
    @(posedge clk_i); @(negedge clk_i);
    fetch_req_i = 1'b0; data_req_i = 1'b0;
    check(tag, "ready", ready_o, 1);
    check(tag, "ale", ale_o, 0);
    check(tag, "strobes", {psen_no, rd_no, wr_no}, 3'b111);
    @(negedge clk_i);
    check(tag, "no done", done_o, 0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3;
    check("R1", "ready in reset", ready_o, 1);
    check("R1", "strobes in reset", {psen_no, rd_no, wr_no, ale_o, p0_oe_o}, 5'b11100);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "ready", ready_o, 1);
    check("R1", "stall/done", {stall_o, done_o}, 0);
    check("R1", "dps", dps_o, 0);
    check("R1", "dptr", dptr_o, 0);
    check("R11", "p2 idle", p2_o, 8'h5A);

    // R2 fetch split with ext_only_ni high
    for (int i = 0; i < 16; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h1111 + i * 3);
      fetch_addr_i = a; fetch_req_i = 1'b1;
      if (a >= 16'h4000) bus_cycle(0, a, 8'h00, 8'(a ^ 16'h3C), "R2 offchip");
      else no_cycle("R2 onchip");
    end
    // boundary
    fetch_addr_i = 16'h3FFF; fetch_req_i = 1'b1; no_cycle("R2 boundary low");
    fetch_addr_i = 16'h4000; fetch_req_i = 1'b1; bus_cycle(0, 16'h4000, 0, 8'h77, "R2 boundary high");
    // R2 external-only forces low addresses off-chip
    ext_only_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = 16'(i * 16'h0F31);
      fetch_addr_i = a; fetch_req_i = 1'b1;
      bus_cycle(0, a, 0, 8'(8'hC3 + i), "R2 forced");
    end
    ext_only_ni = 1'b1;

    // R7 register-indirect writes and reads
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ri, p2, wd;
      ri = 8'(i * 37); p2 = 8'(8'hC0 + i); wd = ri ^ 8'hA5;
      p2_latch_i = p2; ri_val_i = ri; wdata_i = wd;
      data_we_i = 1'b1; data_ptr_i = 1'b0; data_req_i = 1'b1;
      bus_cycle(2, {p2, ri}, wd, 0, "R7 R6 write");
      data_we_i = 1'b0; data_req_i = 1'b1;
      bus_cycle(1, {p2, ri}, 0, 8'(~wd), "R7 R5 read");
    end
    p2_latch_i = 8'h3E;
    @(negedge clk_i);
    check("R11", "p2 follows latch", p2_o, 8'h3E);
    check("R11", "p0 released", p0_oe_o, 0);

    // R8 pointer bank
    dps_wdata_i = 8'h00; dps_wr_i = 1'b1; dptr_wdata_i = 16'h1234; dptr_wr_i = 1'b1;
    @(negedge clk_i);
    dps_wr_i = 1'b0; dptr_wr_i = 1'b0;
    check("R8", "dptr0", dptr_o, 16'h1234);
    dps_wdata_i = 8'hF1; dps_wr_i = 1'b1;
    @(negedge clk_i);
    dps_wr_i = 1'b0;
    check("R8", "sel bit0", dps_o, 1);
    check("R8", "dptr1 untouched", dptr_o, 0);
    dptr_wdata_i = 16'hBEEF; dptr_wr_i = 1'b1;
    @(negedge clk_i);
    dptr_wr_i = 1'b0;
    check("R8", "dptr1", dptr_o, 16'hBEEF);
    data_ptr_i = 1'b1; data_we_i = 1'b0; data_req_i = 1'b1;
    bus_cycle(1, 16'hBEEF, 0, 8'h99, "R8 read dptr1");
    data_we_i = 1'b1; wdata_i = 8'h42; data_req_i = 1'b1;
    bus_cycle(2, 16'hBEEF, 8'h42, 0, "R8 write dptr1");
    dps_wdata_i = 8'h02; dps_wr_i = 1'b1;
    @(negedge clk_i);
    dps_wr_i = 1'b0;
    check("R8", "sel back to 0", dps_o, 0);
    check("R8", "dptr0 kept", dptr_o, 16'h1234);
    data_we_i = 1'b0; data_req_i = 1'b1;
    bus_cycle(1, 16'h1234, 0, 8'h5C, "R8 read dptr0");

    // R10 fetch priority over same-cycle data request
    fetch_addr_i = 16'h8001; fetch_req_i = 1'b1;
    data_req_i = 1'b1; data_we_i = 1'b1; data_ptr_i = 1'b0;
    bus_cycle(0, 16'h8001, 0, 8'h11, "R10 priority");
    // on-chip fetch leaves room for data request
    fetch_addr_i = 16'h0010; fetch_req_i = 1'b1;
    p2_latch_i = 8'h21; ri_val_i = 8'h43; wdata_i = 8'h65;
    data_req_i = 1'b1; data_we_i = 1'b1; data_ptr_i = 1'b0;
    bus_cycle(2, 16'h2143, 8'h65, 0, "R2 R10 onchip+data");
    // R10 request during busy ignored
    inject_busy = 1'b1;
    fetch_addr_i = 16'hF00D; fetch_req_i = 1'b1;
    bus_cycle(0, 16'hF00D, 0, 8'hAB, "R10 busy");
    inject_busy = 1'b0;
    @(negedge clk_i);
    check("R10", "no second cycle ready", ready_o, 1);
    check("R10", "no second cycle wr_no", wr_no, 1);
    check("R10", "no second done", done_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule